// File: doc/BRIEF.md
# Parallel ATA PIO Host Cycle Sequencer

This block runs one programmed-I/O transfer at a time on the host side of a 16-bit parallel ATA-style bus. A local requester hands it a request: a four-bit address whose top bit picks the command or control chip select, a direction flag, a flag for an 8-bit register access versus a 16-bit data access, write data, and a transfer mode from 0 to 6. The sequencer then drives the address and chip select, waits out the address setup time, pulls the read or write strobe low for the minimum active width, and keeps the address, chip select and write data on the bus long enough to meet the hold, recovery and total cycle time limits of that mode.

Every timing limit is held in nanoseconds and turned into clock cycles by rounding up against the clock period parameter. In modes 0 to 4 the device may hold its ready line low to stretch the active phase. The stretch is cut off after a bounded time, and that cut-off sets a sticky error flag. In modes 5 and 6 the ready line is not looked at. The read data is captured on the edge that ends the strobe and is returned with a one-cycle done pulse.

Top module: `pio_cycle_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a request is taken, `req_ready` is 1, both strobes are high, `ata_cs_n` is 2'b11, `ata_doe` is 0, and `rsp_done` and `tmo_err` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the bus cycle has fully ended, and it is 0 whenever a chip select or strobe is active.
- R3: From the edge after acceptance until the cycle ends, `ata_addr` equals `req_addr[2:0]`. `ata_cs_n` is 2'b10 when `req_addr[3]` is 0 and 2'b01 when it is 1, and both stay stable for the whole cycle.
- R4: The strobe goes low after exactly ceil(Ts/Tclk) cycles of address and chip select, where Ts for modes 0..6 is 70, 50, 30, 30, 25, 15, 10 ns.
- R5: For a 16-bit data access with the ready line high, the strobe stays low for exactly ceil(Tw/Tclk) cycles, where Tw for modes 0..6 is 165, 125, 100, 80, 70, 65, 55 ns.
- R6: For an 8-bit register access, the strobe width in modes 0, 1 and 2 is ceil(290 ns/Tclk). In modes 3 to 6 it equals the data width of R5.
- R7: After the strobe rises, the chip select and address stay driven for P = max(C0 − Cs − Cw, Cr, Ch, 1) cycles, and then `req_ready` returns to 1. C0 is ceil of the cycle time (600, 383, 240, 180, 120, 100, 80 ns). Cs and Cw are the setup and width counts actually used. Cr is ceil of the recovery time (0, 0, 0, 70, 25, 25, 20 ns). Ch is ceil of the hold time (30, 20, 15, 10, 10, 10, 10 ns).
- R8: A write drives only `ata_wr_n` low. It also drives `ata_doe`=1 with `ata_dout` equal to the request write data for the whole cycle. A read drives only `ata_rd_n` low and keeps `ata_doe` at 0.
- R9: `ata_din` is captured on the edge that raises the read strobe. `rsp_done` is high for exactly the one cycle after every strobe release. During that cycle `rsp_rdata` holds the captured read data.
- R10: In modes 0 to 4, if `ata_iordy` is low at the end of the minimum width, the strobe stays low and rises on the first edge where `ata_iordy` is sampled high.
- R11: In modes 0 to 4, if `ata_iordy` stays low, the strobe is released after the minimum width plus ceil(1250 ns/Tclk) cycles. `tmo_err` is then set and stays 1 until reset.
- R12: In modes 5 and 6, `ata_iordy` has no effect: the strobe width is that of R5/R6 and `tmo_err` is unchanged.
- R13: The mode and access flags are sampled only at acceptance, so changing them during a cycle has no effect on it. A mode value of 7 is timed as mode 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 4 | Bit 3 selects chip select 1, bits 2:0 are the bus address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg8 | input | 1 | 1 = 8-bit register access, 0 = 16-bit data access |
| req_wdata | input | 16 | Write data |
| req_mode | input | 3 | Transfer mode 0..6 (7 treated as 6) |
| rsp_done | output | 1 | One-cycle pulse after strobe release |
| rsp_rdata | output | 16 | Captured read data |
| tmo_err | output | 1 | Sticky ready-line timeout flag |
| ata_addr | output | 3 | Bus address |
| ata_cs_n | output | 2 | Active-low chip selects |
| ata_rd_n | output | 1 | Active-low read strobe |
| ata_wr_n | output | 1 | Active-low write strobe |
| ata_dout | output | 16 | Bus write data |
| ata_doe | output | 1 | Write data output enable |
| ata_din | input | 16 | Bus read data |
| ata_iordy | input | 1 | Device ready line |

## Verification
The bench runs cycles in every mode, mixing data and register accesses, reads and writes, and both chip selects. This tells apart the separate setup, width and post-strobe counts of each mode and shows whether the longer register strobe stops at mode 2. Three ready-line patterns are used: held high, released after a chosen delay, and stuck low. These separate a correct wait from a missing wait, a timeout from a normal release, and the slow modes from the fast modes that must ignore the line. A mode value of 7 and a mode input scrambled right after acceptance show that timing follows the value latched at the start of the cycle.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_WAIT,
    ST_POST
  } seq_state_e;

  localparam int NUM_MODES    = 7;
  localparam int IORDY_MAX_NS = 1250;
  localparam int LAST_WAIT_MODE = 4;

  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int cycle_ns(input int m);
    case (m)
      0: return 600;
      1: return 383;
      2: return 240;
      3: return 180;
      4: return 120;
      5: return 100;
      default: return 80;
    endcase
  endfunction

  function automatic int setup_ns(input int m);
    case (m)
      0: return 70;
      1: return 50;
      2: return 30;
      3: return 30;
      4: return 25;
      5: return 15;
      default: return 10;
    endcase
  endfunction

  function automatic int width_ns(input int m, input bit reg8);
    if (reg8 && m <= 2) return 290;
    case (m)
      0: return 165;
      1: return 125;
      2: return 100;
      3: return 80;
      4: return 70;
      5: return 65;
      default: return 55;
    endcase
  endfunction

  function automatic int recov_ns(input int m);
    case (m)
      3: return 70;
      4: return 25;
      5: return 25;
      6: return 20;
      default: return 0;
    endcase
  endfunction

  // larger of data hold and address hold after strobe release
  function automatic int hold_ns(input int m);
    case (m)
      0: return 30;
      1: return 20;
      2: return 15;
      default: return 10;
    endcase
  endfunction

  function automatic int post_cyc(input int m, input bit reg8, input int clk_ps);
    int rem;
    int res;
    rem = ns_to_cyc(cycle_ns(m), clk_ps) - ns_to_cyc(setup_ns(m), clk_ps)
        - ns_to_cyc(width_ns(m, reg8), clk_ps);
    res = 1;
    if (rem > res) res = rem;
    if (ns_to_cyc(recov_ns(m), clk_ps) > res) res = ns_to_cyc(recov_ns(m), clk_ps);
    if (ns_to_cyc(hold_ns(m), clk_ps) > res) res = ns_to_cyc(hold_ns(m), clk_ps);
    return res;
  endfunction

endpackage

// File: rtl/pio_timing_lut.sv
module pio_timing_lut
  import pio_seq_pkg::*;
#(
  parameter int CLK_PS = 4000,
  parameter int CNT_W  = 12,
  parameter int MODE_W = 3
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              reg8_i,
  output logic [CNT_W-1:0]  setup_cyc_o,
  output logic [CNT_W-1:0]  width_cyc_o,
  output logic [CNT_W-1:0]  post_cyc_o,
  output logic [CNT_W-1:0]  wait_cyc_o,
  output logic              iordy_en_o
);

  localparam int TOP_MODE = NUM_MODES - 1;

  logic [CNT_W-1:0] setup_tab  [NUM_MODES];
  logic [CNT_W-1:0] wdata_tab  [NUM_MODES];
  logic [CNT_W-1:0] wreg_tab   [NUM_MODES];
  logic [CNT_W-1:0] pdata_tab  [NUM_MODES];
  logic [CNT_W-1:0] preg_tab   [NUM_MODES];
  logic [2:0]       idx;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    assign setup_tab[m] = CNT_W'(ns_to_cyc(setup_ns(m), CLK_PS));
    assign wdata_tab[m] = CNT_W'(ns_to_cyc(width_ns(m, 1'b0), CLK_PS));
    assign wreg_tab[m]  = CNT_W'(ns_to_cyc(width_ns(m, 1'b1), CLK_PS));
    assign pdata_tab[m] = CNT_W'(post_cyc(m, 1'b0, CLK_PS));
    assign preg_tab[m]  = CNT_W'(post_cyc(m, 1'b1, CLK_PS));
  end

  always_comb begin
    if (int'(mode_i) > TOP_MODE) idx = 3'(TOP_MODE);
    else                         idx = 3'(mode_i);
  end

  assign setup_cyc_o = setup_tab[idx];
  assign width_cyc_o = reg8_i ? wreg_tab[idx] : wdata_tab[idx];
  assign post_cyc_o  = reg8_i ? preg_tab[idx] : pdata_tab[idx];
  assign wait_cyc_o  = CNT_W'(ns_to_cyc(IORDY_MAX_NS, CLK_PS));
  assign iordy_en_o  = (int'(idx) <= LAST_WAIT_MODE);

endmodule

// File: rtl/pio_phase_timer.sv
module pio_phase_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (load_i)            cnt_d = val_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
  import pio_seq_pkg::*;
#(
  parameter int CLK_PS = 4000,
  parameter int CNT_W  = 12,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W:0]   req_addr,
  input  logic              req_write,
  input  logic              req_reg8,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [MODE_W-1:0] req_mode,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              tmo_err,
  output logic [ADDR_W-1:0] ata_addr,
  output logic [1:0]        ata_cs_n,
  output logic              ata_rd_n,
  output logic              ata_wr_n,
  output logic [DATA_W-1:0] ata_dout,
  output logic              ata_doe,
  input  logic [DATA_W-1:0] ata_din,
  input  logic              ata_iordy
);

  seq_state_e        state_q, state_d;
  logic [ADDR_W:0]   addr_q;
  logic              write_q, reg8_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [MODE_W-1:0] mode_q;
  logic              done_q, err_q;

  logic              idle, accept, release_s, tmo_s, strobe_on;
  logic [MODE_W-1:0] lut_mode;
  logic              lut_reg8;
  logic [CNT_W-1:0]  setup_cyc, width_cyc, post_cyc, wait_cyc;
  logic              iordy_en;
  logic              tmr_load, tmr_last;
  logic [CNT_W-1:0]  tmr_val;

  assign idle     = (state_q == ST_IDLE);
  assign accept   = idle && req_valid;
  assign lut_mode = idle ? req_mode : mode_q;
  assign lut_reg8 = idle ? req_reg8 : reg8_q;

  pio_timing_lut #(
    .CLK_PS (CLK_PS),
    .CNT_W  (CNT_W),
    .MODE_W (MODE_W)
  ) u_lut (
    .mode_i      (lut_mode),
    .reg8_i      (lut_reg8),
    .setup_cyc_o (setup_cyc),
    .width_cyc_o (width_cyc),
    .post_cyc_o  (post_cyc),
    .wait_cyc_o  (wait_cyc),
    .iordy_en_o  (iordy_en)
  );

  pio_phase_timer #(
    .CNT_W (CNT_W)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .last_o (tmr_last)
  );

  // next-state and phase timer control
  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = post_cyc;
    release_s = 1'b0;
    tmo_s     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = setup_cyc;
        end
      end
      ST_SETUP: begin
        if (tmr_last) begin
          state_d  = ST_ACTIVE;
          tmr_load = 1'b1;
          tmr_val  = width_cyc;
        end
      end
      ST_ACTIVE: begin
        if (tmr_last) begin
          tmr_load = 1'b1;
          if (iordy_en && !ata_iordy) begin
            state_d = ST_WAIT;
            tmr_val = wait_cyc;
          end else begin
            state_d   = ST_POST;
            release_s = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (ata_iordy || tmr_last) begin
          state_d   = ST_POST;
          tmr_load  = 1'b1;
          release_s = 1'b1;
          tmo_s     = !ata_iordy;
        end
      end
      ST_POST: begin
        if (tmr_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // request capture, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      reg8_q  <= 1'b0;
      wdata_q <= '0;
      mode_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      write_q <= req_write;
      reg8_q  <= req_reg8;
      wdata_q <= req_wdata;
      mode_q  <= req_mode;
    end
  end

  // read capture on strobe release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rdata_q <= '0;
    else if (release_s && !write_q) rdata_q <= ata_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= release_s;
      if (tmo_s) err_q <= 1'b1;
    end
  end

  assign strobe_on = (state_q == ST_ACTIVE) || (state_q == ST_WAIT);

  assign req_ready = idle;
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
  assign tmo_err   = err_q;
  assign ata_addr  = addr_q[ADDR_W-1:0];
  assign ata_cs_n  = idle ? 2'b11 : (addr_q[ADDR_W] ? 2'b01 : 2'b10);
  assign ata_rd_n  = !(strobe_on && !write_q);
  assign ata_wr_n  = !(strobe_on && write_q);
  assign ata_dout  = wdata_q;
  assign ata_doe   = !idle && write_q;

endmodule

// File: rtl/pio_cycle_seq_chk.sv
module pio_cycle_seq_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              tmo_err,
  input logic [ADDR_W-1:0] ata_addr,
  input logic [1:0]        ata_cs_n,
  input logic              ata_rd_n,
  input logic              ata_wr_n,
  input logic              ata_doe,
  input logic [DATA_W-1:0] ata_dout
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ata_cs_n == 2'b11 && ata_rd_n && ata_wr_n && !ata_doe));

  a_r2_busy_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_rd_n || !ata_wr_n) |-> !req_ready);

  a_r3_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ata_cs_n != 2'b11 && $past(ata_cs_n) != 2'b11) |->
      ($stable(ata_addr) && $stable(ata_cs_n)));

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_rd_n && !ata_wr_n));

  a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    ata_doe |-> ata_rd_n);

  a_r8_wdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (ata_doe && $past(ata_doe) && ata_cs_n != 2'b11) |-> $stable(ata_dout));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r9_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ata_rd_n) || $rose(ata_wr_n)) |-> rsp_done);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |=> tmo_err);

endmodule

bind pio_cycle_seq pio_cycle_seq_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .tmo_err   (tmo_err),
  .ata_addr  (ata_addr),
  .ata_cs_n  (ata_cs_n),
  .ata_rd_n  (ata_rd_n),
  .ata_wr_n  (ata_wr_n),
  .ata_doe   (ata_doe),
  .ata_dout  (ata_dout)
);

// File: tb/pio_cycle_seq_test.sv
module pio_cycle_seq_test;

  localparam int CLK_PS = 4000;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [3:0]  req_addr;
  logic        req_write;
  logic        req_reg8;
  logic [15:0] req_wdata;
  logic [2:0]  req_mode;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        tmo_err;
  logic [2:0]  ata_addr;
  logic [1:0]  ata_cs_n;
  logic        ata_rd_n;
  logic        ata_wr_n;
  logic [15:0] ata_dout;
  logic        ata_doe;
  logic [15:0] ata_din;
  logic        ata_iordy;

  pio_cycle_seq #(.CLK_PS(CLK_PS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_reg8(req_reg8),
    .req_wdata(req_wdata), .req_mode(req_mode), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .tmo_err(tmo_err), .ata_addr(ata_addr),
    .ata_cs_n(ata_cs_n), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n),
    .ata_dout(ata_dout), .ata_doe(ata_doe), .ata_din(ata_din),
    .ata_iordy(ata_iordy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit err_exp = 0;

  typedef struct {
    bit          wr;
    logic [3:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdin;
    int          wait_l;
    int          e_setup;
    int          e_width;
    int          e_post;
    bit          e_tmo;
  } exp_t;

  exp_t q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int cyc(input int ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction

  function automatic int t_cyc(input int m);
    int t[7] = '{600, 383, 240, 180, 120, 100, 80};
    return t[m];
  endfunction
  function automatic int t_set(input int m);
    int t[7] = '{70, 50, 30, 30, 25, 15, 10};
    return t[m];
  endfunction
  function automatic int t_wid(input int m, input bit r8);
    int t[7]  = '{165, 125, 100, 80, 70, 65, 55};
    if (r8 && m < 3) return 290;
    return t[m];
  endfunction
  function automatic int t_rec(input int m);
    int t[7] = '{0, 0, 0, 70, 25, 25, 20};
    return t[m];
  endfunction
  function automatic int t_hld(input int m);
    int t[7] = '{30, 20, 15, 10, 10, 10, 10};
    return t[m];
  endfunction

  // wait_l: 0 = ready high, >0 = raise ready at that low-strobe count, -1 = stuck low
  task automatic do_cycle(input int mode, input bit wr, input bit r8,
                          input logic [3:0] addr, input logic [15:0] wd,
                          input logic [15:0] rd, input int wait_l);
    exp_t e;
    int m, c0, c1, c2, p;
    m  = (mode > 6) ? 6 : mode;
    c0 = cyc(t_cyc(m));
    c1 = cyc(t_set(m));
    c2 = cyc(t_wid(m, r8));
    p  = c0 - c1 - c2;
    if (p < 1) p = 1;
    if (cyc(t_rec(m)) > p) p = cyc(t_rec(m));
    if (cyc(t_hld(m)) > p) p = cyc(t_hld(m));
    e.wr = wr; e.addr = addr; e.wdata = wd; e.rdin = rd; e.wait_l = wait_l;
    e.e_setup = c1; e.e_post = p; e.e_tmo = 0;
    if (m > 4 || wait_l == 0) e.e_width = c2;
    else if (wait_l > 0)      e.e_width = wait_l;
    else begin
      e.e_width = c2 + cyc(1250);
      e.e_tmo   = 1;
    end
    q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    ata_din   = rd;
    req_addr  = addr;
    req_write = wr;
    req_reg8  = r8;
    req_wdata = wd;
    req_mode  = 3'(mode);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R13: scramble request fields after acceptance
    req_mode  = 3'(mode + 3);
    req_reg8  = ~r8;
    req_write = ~wr;
    req_wdata = ~wd;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  // monitor / scoreboard
  bit   in_cyc = 0;
  bit   seen = 0;
  int   n_set, n_wid, n_post;
  exp_t cur;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (ata_cs_n != 2'b11) begin
        if (!in_cyc) begin
          in_cyc = 1; seen = 0; n_set = 0; n_wid = 0; n_post = 0;
          if (q.size() == 0) begin
            chk(0, "R2", "unexpected bus cycle", 1, 0);
            cur.wait_l = 0; cur.wr = 0; cur.addr = '0; cur.e_tmo = 0;
          end else cur = q.pop_front();
          ata_iordy = (cur.wait_l == 0);
          chk(ata_addr == cur.addr[2:0], "R3", "address", ata_addr, cur.addr[2:0]);
          chk(ata_cs_n == (cur.addr[3] ? 2'b01 : 2'b10), "R3", "chip select",
              ata_cs_n, cur.addr[3] ? 1 : 2);
        end
        chk(!req_ready, "R2", "ready during cycle", req_ready, 0);
        if (!ata_rd_n || !ata_wr_n) begin
          n_wid++;
          seen = 1;
          if (n_wid == 1) begin
            chk(ata_wr_n == !cur.wr && ata_rd_n == cur.wr, "R8", "strobe select",
                {ata_rd_n, ata_wr_n}, cur.wr ? 2 : 1);
            chk(ata_doe == cur.wr, "R8", "data enable", ata_doe, cur.wr);
            if (cur.wr) chk(ata_dout == cur.wdata, "R8", "write data", ata_dout, cur.wdata);
          end
          if (cur.wait_l > 0 && n_wid == cur.wait_l) ata_iordy = 1'b1;
        end else if (!seen) begin
          n_set++;
        end else begin
          n_post++;
          if (n_post == 1) begin
            chk(rsp_done, "R9", "done after release", rsp_done, 1);
            if (!cur.wr) chk(rsp_rdata == cur.rdin, "R9", "read data", rsp_rdata, cur.rdin);
          end else if (rsp_done) chk(0, "R9", "done width", 1, 0);
        end
      end else if (in_cyc) begin
        in_cyc = 0;
        ata_iordy = 1'b1;
        err_exp = err_exp | cur.e_tmo;
        chk(n_set == cur.e_setup, "R4", "setup cycles", n_set, cur.e_setup);
        chk(n_wid == cur.e_width, "R5 R6 R10 R11 R12", "strobe cycles", n_wid, cur.e_width);
        chk(n_post == cur.e_post, "R7", "post-strobe cycles", n_post, cur.e_post);
        chk(req_ready, "R7", "ready after cycle", req_ready, 1);
        chk(tmo_err == err_exp, "R11", "timeout flag", tmo_err, err_exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_addr = '0; req_write = 0; req_reg8 = 0;
    req_wdata = '0; req_mode = '0; ata_din = '0; ata_iordy = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1", "ready in reset", req_ready, 1);
    chk(ata_rd_n && ata_wr_n, "R1", "strobes in reset", {ata_rd_n, ata_wr_n}, 3);
    chk(ata_cs_n == 2'b11, "R1", "cs in reset", ata_cs_n, 3);
    chk(!ata_doe && !rsp_done && !tmo_err, "R1", "doe/done/err in reset",
        {ata_doe, rsp_done, tmo_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && ata_cs_n == 2'b11, "R1", "idle after reset", req_ready, 1);

    // R4 R5 R7 R9: data accesses across modes, both chip selects
    do_cycle(0, 0, 0, 4'h3, 16'h0000, 16'hA55A, 0);
    do_cycle(1, 1, 0, 4'hE, 16'h1234, 16'h0000, 0);
    do_cycle(2, 0, 0, 4'h0, 16'h0000, 16'h8001, 0);
    do_cycle(3, 1, 0, 4'h9, 16'hBEEF, 16'h0000, 0);
    do_cycle(4, 0, 0, 4'h7, 16'h0000, 16'h7FFE, 0);
    do_cycle(5, 1, 0, 4'h2, 16'h4321, 16'h0000, 0);
    do_cycle(6, 0, 0, 4'hF, 16'h0000, 16'hC3C3, 0);
    // R6 register accesses: long strobe in modes 0..2, data width from mode 3
    do_cycle(0, 1, 1, 4'hE, 16'h00AB, 16'h0000, 0);
    do_cycle(2, 0, 1, 4'h6, 16'h0000, 16'h005C, 0);
    do_cycle(3, 0, 1, 4'h1, 16'h0000, 16'h0033, 0);
    do_cycle(6, 1, 1, 4'hC, 16'h0077, 16'h0000, 0);
    // R10 ready-line stretch
    do_cycle(1, 0, 0, 4'h5, 16'h0000, 16'h5AA5, cyc(125) + 20);
    do_cycle(4, 1, 1, 4'h4, 16'h0011, 16'h0000, cyc(70) + 1);
    // R12 fast modes ignore a low ready line
    do_cycle(5, 0, 0, 4'h3, 16'h0000, 16'h1111, -1);
    // R13 mode 7 timed as mode 6, ready line ignored
    do_cycle(7, 0, 0, 4'hA, 16'h0000, 16'h2222, -1);
    // R11 timeout and sticky flag
    do_cycle(4, 0, 0, 4'h1, 16'h0000, 16'h3333, -1);
    do_cycle(0, 1, 0, 4'h2, 16'h9999, 16'h0000, 0);

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R2", "all requests served", q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule